// File: doc/BRIEF.md
# Timer capture and match-output unit

This block holds a 16-bit counter that advances by one on every clock and wraps without stopping. Two capture channels watch asynchronous input pins. When a channel sees an edge it has been set to look for (rising, falling or either), it copies the counter into its own capture register. Four match channels each compare the counter with a programmable value. When the two are equal, the channel changes its output bit according to a 2-bit action code: it can hold, clear, set or toggle the bit.

Software uses a word-addressed register port to configure the unit. It writes the match values, the capture edge selection and a combined output-control word. That word holds the output bits, the action codes and a per-channel flag that suppresses match actions for channels driven by other logic. Software reads back every register, including the two capture values. The output bits appear on a port whether or not they are routed on to pins.

Top module: `tmr_capmatch`

## Requirements
- R1: While `rst_n` is low, the counter, the match outputs, the match values, the capture control, the actions, the suppress flags and both capture registers are all 0.
- R2: The counter increases by 1 on every clock edge out of reset and wraps from 0xFFFF to 0x0000.
- R3: Capture control (address 4) selects the trigger for capture channel k in bits [2k+1:2k]: 00 never, 01 rising edge, 10 falling edge, 11 either edge. An edge of a kind that is not selected leaves the capture register unchanged.
- R4: Capture inputs are synchronized by two flops. A pin change sampled at the clock edge where `tmr_count` shows V loads V+2 into that channel's capture register. The register is readable at address 6+k, with bits 31:16 read as 0.
- R5: The output-control word is at address 5. Bits 3:0 are the outputs, bits [5+2n:4+2n] are the action of match channel n, and bits 15:12 are the suppress flags. While the counter equals match value n (address n), the next edge applies the action: 00 hold, 01 clear, 10 set, 11 toggle.
- R6: Writing address 5 loads bits 3:0 into the outputs. If the same edge carries a match action for channel n that is neither suppressed nor 00, that action wins for bit n.
- R7: While suppress flag n (bit 12+n) is 1, a match on channel n leaves output n unchanged, and a software write still sets it.
- R8: Addresses 0–3 read the match values, 4 the capture control, 5 the output-control word and 6–7 the captures, with unused bits as 0. Addresses 8–15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Word address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| cap_in | input | 2 | Capture input pins, asynchronous |
| match_out | output | 4 | Match output bits |
| tmr_count | output | 16 | Current counter value |

## Verification
The bench steps a reference model alongside the unit and compares the counter, the match outputs and the read data after every clock. A wrong action decode or a lost priority shows at `match_out` on the clock after the counter passes the match value. A wrong synchronizer depth or edge test shows as a capture value off by one or more counts, or as an update that should not happen. Either kind of fault is visible through address 6 or 7 within four clocks of the pin change.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } match_act_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } cap_edge_e;
endpackage

// File: rtl/tmr_capture_chan.sv
module tmr_capture_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  cap_edge_e        edge_sel,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap_val
);
  logic             s1_q, s2_q, s3_q;
  logic             rise, fall, fire;
  logic [CNT_W-1:0] cap_q, cap_d;

  always_comb begin
    rise = s2_q & ~s3_q;
    fall = ~s2_q & s3_q;
    unique case (edge_sel)
      EDGE_RISE: fire = rise;
      EDGE_FALL: fire = fall;
      EDGE_ANY:  fire = rise | fall;
      default:   fire = 1'b0;
    endcase
    cap_d = fire ? count : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      cap_q <= '0;
    end else begin
      s1_q  <= pin;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      cap_q <= cap_d;
    end
  end

  assign cap_val = cap_q;

  p_cap_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> cap_val == $past(count));
  p_cap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(cap_val));
  p_cap_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == EDGE_OFF) |=> $stable(cap_val));
endmodule

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] match_val,
  input  match_act_e       act,
  input  logic             suppress,
  input  logic             sw_wr,
  input  logic             sw_val,
  output logic             out_bit
);
  logic hit, act_live;
  logic out_q, out_d;

  always_comb begin
    hit      = (count == match_val);
    act_live = hit && !suppress && (act != ACT_HOLD);
    out_d    = out_q;
    if (act_live) begin
      unique case (act)
        ACT_LOW:  out_d = 1'b0;
        ACT_HIGH: out_d = 1'b1;
        ACT_FLIP: out_d = ~out_q;
        default:  out_d = out_q;
      endcase
    end else if (sw_wr) begin
      out_d = sw_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign out_bit = out_q;

  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !sw_wr) |=> $stable(out_bit));
  p_out_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !suppress && act == ACT_HIGH) |=> out_bit);
  p_out_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !suppress && act == ACT_LOW) |=> !out_bit);
  p_out_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !suppress && act == ACT_FLIP) |=> out_bit != $past(out_bit));
  p_sw_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !(hit && !suppress && act != ACT_HOLD)) |=> out_bit == $past(sw_val));
  p_suppress_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (suppress && !sw_wr) |=> $stable(out_bit));
endmodule

// File: rtl/tmr_capmatch.sv
module tmr_capmatch
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int N_CAP   = 2,
  parameter int N_MATCH = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [N_CAP-1:0]   cap_in,
  output logic [N_MATCH-1:0] match_out,
  output logic [CNT_W-1:0]   tmr_count
);
  localparam int A_CAPCTL = N_MATCH;
  localparam int A_EXT    = N_MATCH + 1;
  localparam int A_CAP0   = N_MATCH + 2;
  localparam int ACT_LSB  = N_MATCH;
  localparam int ACT_W    = 2 * N_MATCH;
  localparam int PWM_LSB  = ACT_LSB + ACT_W;
  localparam int EXT_W    = PWM_LSB + N_MATCH;
  localparam int CC_W     = 2 * N_CAP;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] mr_q [N_MATCH];
  logic [CNT_W-1:0] mr_d [N_MATCH];
  logic [CNT_W-1:0] cap_val [N_CAP];
  logic [CC_W-1:0]  cc_q, cc_d;
  logic [ACT_W-1:0] act_q, act_d;
  logic [N_MATCH-1:0] sup_q, sup_d;
  logic             wr_ext;
  logic             unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:EXT_W];

  // next-state for counter and configuration registers
  always_comb begin
    cnt_d  = cnt_q + CNT_W'(1);
    cc_d   = cc_q;
    act_d  = act_q;
    sup_d  = sup_q;
    wr_ext = wr_en && (addr == ADDR_W'(A_EXT));
    for (int i = 0; i < N_MATCH; i++) begin
      mr_d[i] = mr_q[i];
      if (wr_en && addr == ADDR_W'(i)) mr_d[i] = wdata[CNT_W-1:0];
    end
    if (wr_en && addr == ADDR_W'(A_CAPCTL)) cc_d = wdata[CC_W-1:0];
    if (wr_ext) begin
      act_d = wdata[ACT_LSB +: ACT_W];
      sup_d = wdata[PWM_LSB +: N_MATCH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cc_q  <= '0;
      act_q <= '0;
      sup_q <= '0;
      for (int i = 0; i < N_MATCH; i++) mr_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      cc_q  <= cc_d;
      act_q <= act_d;
      sup_q <= sup_d;
      for (int i = 0; i < N_MATCH; i++) mr_q[i] <= mr_d[i];
    end
  end

  assign tmr_count = cnt_q;

  generate
    for (genvar g = 0; g < N_MATCH; g++) begin : g_match
      tmr_match_chan #(.CNT_W(CNT_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .count    (cnt_q),
        .match_val(mr_q[g]),
        .act      (match_act_e'(act_q[2*g +: 2])),
        .suppress (sup_q[g]),
        .sw_wr    (wr_ext),
        .sw_val   (wdata[g]),
        .out_bit  (match_out[g])
      );
    end
    for (genvar g = 0; g < N_CAP; g++) begin : g_cap
      tmr_capture_chan #(.CNT_W(CNT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (cap_in[g]),
        .edge_sel(cap_edge_e'(cc_q[2*g +: 2])),
        .count   (cnt_q),
        .cap_val (cap_val[g])
      );
    end
  endgenerate

  // read mux
  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_MATCH; i++)
      if (addr == ADDR_W'(i)) rdata = DATA_W'(mr_q[i]);
    if (addr == ADDR_W'(A_CAPCTL)) rdata = DATA_W'(cc_q);
    if (addr == ADDR_W'(A_EXT))    rdata = DATA_W'({sup_q, act_q, match_out});
    for (int k = 0; k < N_CAP; k++)
      if (addr == ADDR_W'(A_CAP0 + k)) rdata = DATA_W'(cap_val[k]);
  end

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tmr_count == $past(tmr_count) + CNT_W'(1));
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(cc_q) && $stable(act_q) && $stable(sup_q)));
endmodule

// File: tb/tmr_capmatch_test.sv
module tmr_capmatch_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [1:0]  cap_in;
  logic [3:0]  match_out;
  logic [15:0] tmr_count;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit run_chk = 1'b0;

  always #4 clk = ~clk;

  tmr_capmatch uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_in(cap_in), .match_out(match_out), .tmr_count(tmr_count)
  );

  // reference model
  logic [15:0] m_cnt, m_mr [4], m_cap [2];
  logic [3:0]  m_cc, m_pwm, m_out, m_no;
  logic [7:0]  m_act;
  logic [1:0]  m_s1, m_s2, m_s3, m_a, m_mode;
  logic        m_r, m_f;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cc = 0; m_pwm = 0; m_out = 0; m_act = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
      for (int i = 0; i < 4; i++) m_mr[i] = 0;
      for (int k = 0; k < 2; k++) m_cap[k] = 0;
    end else begin
      m_no = m_out;
      for (int n = 0; n < 4; n++) begin
        m_a = m_act[2*n +: 2];
        if (m_cnt == m_mr[n] && !m_pwm[n] && m_a != 2'b00) begin
          if (m_a == 2'b01) m_no[n] = 1'b0;
          else if (m_a == 2'b10) m_no[n] = 1'b1;
          else m_no[n] = ~m_out[n];
        end else if (wr_en && addr == 4'd5) m_no[n] = wdata[n];
      end
      for (int k = 0; k < 2; k++) begin
        m_mode = m_cc[2*k +: 2];
        m_r = m_s2[k] & ~m_s3[k];
        m_f = ~m_s2[k] & m_s3[k];
        if ((m_mode == 2'b01 && m_r) || (m_mode == 2'b10 && m_f) || (m_mode == 2'b11 && (m_r || m_f)))
          m_cap[k] = m_cnt;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap_in;
      if (wr_en) begin
        if (addr < 4'd4) m_mr[addr[1:0]] = wdata[15:0];
        if (addr == 4'd4) m_cc = wdata[3:0];
        if (addr == 4'd5) begin m_act = wdata[11:4]; m_pwm = wdata[15:12]; end
      end
      m_out = m_no;
      m_cnt = m_cnt + 16'd1;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    if (a < 4'd4) return {16'd0, m_mr[a[1:0]]};
    if (a == 4'd4) return {28'd0, m_cc};
    if (a == 4'd5) return {16'd0, m_pwm, m_act, m_out};
    if (a == 4'd6) return {16'd0, m_cap[0]};
    if (a == 4'd7) return {16'd0, m_cap[1]};
    return 32'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (run_chk && rst_n && !done) begin
      chk("R2 counter vs model", {16'd0, tmr_count}, {16'd0, m_cnt});
      chk("R5 match_out vs model", {28'd0, match_out}, {28'd0, m_out});
      chk("R8 rdata vs model", rdata, exp_rd(addr));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    do @(negedge clk); while (tmr_count != v);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [15:0] v, m;
    int seed;
    seed = $urandom(32'h5EED1234);
    rst_n = 1'b0; wr_en = 1'b0; addr = 4'd0; wdata = 32'd0; cap_in = 2'b00;
    repeat (3) @(negedge clk);
    addr = 4'd6; #1;
    chk("R1 reset count", {16'd0, tmr_count}, 32'd0);
    chk("R1 reset match_out", {28'd0, match_out}, 32'd0);
    chk("R1 reset capture", rdata, 32'd0);
    addr = 4'd5; #1;
    chk("R1 reset control word", rdata, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    run_chk = 1'b1;

    // R3/R4 capture: ch0 rising, ch1 falling
    wr(4'd4, 32'h9);
    @(negedge clk); v = tmr_count; cap_in = 2'b11;
    repeat (4) @(negedge clk);
    rd_chk("R4 rising capture value", 4'd6, {16'd0, v + 16'd2});
    rd_chk("R3 rising edge ignored in falling mode", 4'd7, 32'd0);
    @(negedge clk); m = tmr_count; cap_in = 2'b00;
    repeat (4) @(negedge clk);
    rd_chk("R4 falling capture value", 4'd7, {16'd0, m + 16'd2});
    rd_chk("R3 falling edge ignored in rising mode", 4'd6, {16'd0, v + 16'd2});
    wr(4'd4, 32'h3);
    @(negedge clk); v = tmr_count; cap_in = 2'b01;
    repeat (4) @(negedge clk);
    rd_chk("R3 both-edge mode rising", 4'd6, {16'd0, v + 16'd2});
    @(negedge clk); v = tmr_count; cap_in = 2'b00;
    repeat (4) @(negedge clk);
    rd_chk("R3 both-edge mode falling", 4'd6, {16'd0, v + 16'd2});
    wr(4'd4, 32'h0);
    @(negedge clk); cap_in = 2'b11;
    repeat (4) @(negedge clk);
    rd_chk("R3 off mode keeps capture", 4'd6, {16'd0, v + 16'd2});
    cap_in = 2'b00;

    // R5 actions on channel 0
    @(negedge clk); m = tmr_count + 16'd40;
    wr(4'd0, {16'd0, m}); wr(4'd5, 32'h20);
    wait_cnt(m); #1;
    chk("R5 output before match", {31'd0, match_out[0]}, 32'd0);
    @(negedge clk); #1;
    chk("R5 set action", {31'd0, match_out[0]}, 32'd1);
    @(negedge clk); m = tmr_count + 16'd40;
    wr(4'd0, {16'd0, m}); wr(4'd5, 32'h11);
    wait_cnt(m); @(negedge clk); #1;
    chk("R5 clear action", {31'd0, match_out[0]}, 32'd0);
    @(negedge clk); m = tmr_count + 16'd40;
    wr(4'd0, {16'd0, m}); wr(4'd5, 32'h30);
    wait_cnt(m); @(negedge clk); #1;
    chk("R5 toggle action up", {31'd0, match_out[0]}, 32'd1);
    @(negedge clk); m = tmr_count + 16'd40;
    wr(4'd0, {16'd0, m});
    wait_cnt(m); @(negedge clk); #1;
    chk("R5 toggle action down", {31'd0, match_out[0]}, 32'd0);
    @(negedge clk); m = tmr_count + 16'd40;
    wr(4'd0, {16'd0, m}); wr(4'd5, 32'h01);
    wait_cnt(m); @(negedge clk); #1;
    chk("R5 hold action", {31'd0, match_out[0]}, 32'd1);

    // R6 software writes and priority
    wr(4'd5, 32'h0A); #1;
    chk("R6 software output write", {28'd0, match_out}, 32'hA);
    @(negedge clk); m = tmr_count + 16'd40;
    wr(4'd0, {16'd0, m}); wr(4'd5, 32'h20);
    wait_cnt(m);
    wr_en = 1'b1; addr = 4'd5; wdata = 32'h20;
    @(negedge clk); wr_en = 1'b0; #1;
    chk("R6 match action wins over write", {31'd0, match_out[0]}, 32'd1);

    // R7 suppress on channel 1
    @(negedge clk); m = tmr_count + 16'd40;
    wr(4'd1, {16'd0, m}); wr(4'd5, 32'h2080);
    wait_cnt(m); @(negedge clk); #1;
    chk("R7 suppressed match no effect", {31'd0, match_out[1]}, 32'd0);
    wr(4'd5, 32'h2082); #1;
    chk("R7 software write under suppress", {31'd0, match_out[1]}, 32'd1);

    // R8 unmapped addresses
    wr(4'd12, 32'hFFFF_FFFF);
    rd_chk("R8 unmapped read zero", 4'd12, 32'd0);
    rd_chk("R8 unmapped write no effect", 4'd1, {16'd0, m});

    // R2 wrap
    wait_cnt(16'hFFFF);
    @(negedge clk); #1;
    chk("R2 counter wraps", {16'd0, tmr_count}, 32'd0);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      wr_en = ($urandom % 4 == 0);
      addr = 4'($urandom % 16);
      wdata = $urandom;
      if (addr < 4'd4) wdata = {16'd0, tmr_count + 16'(2 + $urandom % 48)};
      if ($urandom % 6 == 0) cap_in[$urandom % 2] = ~cap_in[$urandom % 2];
    end
    @(negedge clk); wr_en = 1'b0;
    repeat (2) @(negedge clk);
    #3;
    done = 1'b1;
    summary();
  end
endmodule